// File: doc/BRIEF.md
# Binary-Angle Polar-to-Rectangular Converter

This block turns a polar pair into rectangular components. Each input sample has three parts:

- a 16-bit natural-binary angle,
- a signed 16-bit radius,
- a 2-bit gain code.

For each sample the block returns a signed sine component and a signed cosine component. Both are scaled by the radius and by the selected gain. The radius may be a static (DC) value or one sample of an AC carrier. In either case both outputs carry the same amplitude factor, so a ratiometric receiver sees no error from it.

The two top bits of the angle fold it into the first quadrant. A gain-compensated shift-and-add rotation then produces the first-quadrant sine and cosine. A final stage does three things:

- swaps and negates the pair according to the quadrant,
- multiplies it by the radius,
- rounds and saturates it to the output width.

Samples enter and leave through valid/ready handshakes. All stages advance together, and the pipeline holds still while the output is stalled.

Top module: `pvr_polar_rect`

## Requirements
- R1: The angle input is unsigned. Its value A stands for θ = A·360°/65536, so bit 15 weighs 180° and code 65535 is just short of a full turn.
- R2: For each accepted sample, sin_out = sat(round(4·K·R·sin θ)) and cos_out = sat(round(4·K·R·cos θ)), within ±2 LSB. R is the signed radius and K is the gain.
- R3: gain_sel bit 0 models the first select pin and bit 1 the second, with 1 meaning open and 0 meaning tied low. Code 2'b10 gives K = 0.5, code 2'b01 gives K = 1.0 and code 2'b11 gives K = 2.0.
- R4: The reserved code 2'b00 behaves as K = 1.0.
- R5: A result outside the 18-bit signed range is clipped: to +131071 when positive and to −131072 when negative. It never wraps.
- R6: The quadrant is taken from angle bits 15:14. At every multiple of 90° and its neighbouring codes, the results meet R2.
- R7: Results come out in acceptance order, exactly one per accepted sample. When out_ready stays high, out_valid for a sample rises 23 cycles after the clock edge that accepted it.
- R8: While out_valid is high and out_ready is low, sin_out, cos_out and out_valid hold their values and in_ready is low. Whenever out_valid is low, in_ready is high.
- R9: During and after reset out_valid is low and in_ready is high, until the first accepted sample comes out.
- R10: Whenever neither output saturates, sqrt(sin_out² + cos_out²) stays within 0.1% + 3 LSB of 4·K·|R|, whatever the angle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Block accepts the sample this cycle |
| angle_in | input | 16 | Binary angle, bit 15 = 180° |
| radius_in | input | 16 | Signed two's-complement radius |
| gain_sel | input | 2 | Gain code, two select pins (1 = open) |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| sin_out | output | 18 | Signed sine component |
| cos_out | output | 18 | Signed cosine component |

## Verification
A wrong step direction or a wrong arctangent constant in one rotation stage shows up at both outputs as a small, angle-dependent error. The error shows on the 23rd cycle after acceptance, so the dense angle sweep at a gain that does not saturate is the place it is caught. A quadrant mapping error flips a sign or swaps the two outputs across a whole 90° band, which the axis codes and their neighbours expose at once. A valid bit that slips a stage moves the result away from cycle 23, and a stage enable that ignores a stall lets a held output change. Both are visible in the very next result.

// File: rtl/pvr_pkg.sv
`timescale 1ns/1ps
package pvr_pkg;
    localparam int ANG_W = 16;
    localparam int RAD_W = 16;
    localparam int OUT_W = 18;
    localparam int ITER  = 22;
    localparam int FRAC  = 24;
    localparam int DW    = FRAC + 3;
    localparam int IDX_W = ANG_W - 2;
    localparam int ZX    = FRAC - IDX_W;
    localparam int PW    = DW + RAD_W;

    typedef enum logic [1:0] {
        GAIN_HALF = 2'd0,
        GAIN_ONE  = 2'd1,
        GAIN_TWO  = 2'd2
    } gain_e;

    typedef struct packed {
        logic                    vld;
        logic signed [DW-1:0]    x;
        logic signed [DW-1:0]    y;
        logic signed [DW-1:0]    z;
        logic [1:0]              quad;
        logic signed [RAD_W-1:0] rad;
        gain_e                   gain;
    } rot_t;

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
    } res_t;

    function automatic gain_e gain_decode(input logic [1:0] code);
        case (code)
            2'b10:   return GAIN_HALF;
            2'b11:   return GAIN_TWO;
            default: return GAIN_ONE;
        endcase
    endfunction

    function automatic real frac_scale();
        real s;
        s = 1.0;
        for (int k = 0; k < FRAC; k++) s = s * 2.0;
        return s;
    endfunction

    // arctangent of 2^-i in radians, power series for i >= 1
    function automatic real atan_pow2(input int i);
        real t, term, sum;
        t = 1.0;
        for (int k = 0; k < i; k++) t = t / 2.0;
        if (i == 0) return 0.7853981633974483;
        sum  = 0.0;
        term = t;
        for (int k = 0; k < 40; k++) begin
            sum  = sum + ((k % 2 == 0) ? term : -term) / real'(2 * k + 1);
            term = term * t * t;
        end
        return sum;
    endfunction

    // angle step in units where a quarter turn equals 2^FRAC
    function automatic logic signed [DW-1:0] atan_code(input int i);
        return DW'($rtoi(atan_pow2(i) / 1.5707963267948966 * frac_scale() + 0.5));
    endfunction

    // start vector length pre-divided by the rotation growth
    function automatic logic signed [DW-1:0] start_len();
        return DW'($rtoi(0.6072529350088813 * frac_scale() + 0.5));
    endfunction
endpackage

// File: rtl/pvr_rot_stage.sv
`timescale 1ns/1ps
module pvr_rot_stage
    import pvr_pkg::*;
#(
    parameter int STEP = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  rot_t s_i,
    output rot_t s_o
);
    localparam logic signed [DW-1:0] ANG = atan_code(STEP);

    rot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d = s_i;
            if (s_i.z[DW-1]) begin
                st_d.x = s_i.x + (s_i.y >>> STEP);
                st_d.y = s_i.y - (s_i.x >>> STEP);
                st_d.z = s_i.z + ANG;
            end else begin
                st_d.x = s_i.x - (s_i.y >>> STEP);
                st_d.y = s_i.y + (s_i.x >>> STEP);
                st_d.z = s_i.z - ANG;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_o = st_q;
endmodule

// File: rtl/pvr_scale.sv
`timescale 1ns/1ps
module pvr_scale
    import pvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  rot_t s_i,
    output res_t r_o
);
    localparam logic signed [PW-1:0] ONE  = PW'(1);
    localparam logic signed [PW-1:0] OMAX = (ONE <<< (OUT_W - 1)) - ONE;
    localparam logic signed [PW-1:0] OMIN = -OMAX - ONE;

    function automatic logic signed [PW-1:0] round_shift(input logic signed [PW-1:0] p,
                                                         input gain_e g);
        case (g)
            GAIN_HALF: return (p + (ONE <<< (FRAC - 2))) >>> (FRAC - 1);
            GAIN_TWO:  return (p + (ONE <<< (FRAC - 4))) >>> (FRAC - 3);
            default:   return (p + (ONE <<< (FRAC - 3))) >>> (FRAC - 2);
        endcase
    endfunction

    function automatic logic signed [OUT_W-1:0] clip(input logic signed [PW-1:0] v);
        if (v > OMAX) return OMAX[OUT_W-1:0];
        if (v < OMIN) return OMIN[OUT_W-1:0];
        return v[OUT_W-1:0];
    endfunction

    res_t r_d, r_q;
    logic signed [DW-1:0] us, uc;
    logic signed [PW-1:0] ws, wc, wr;
    logic unused_z;

    assign unused_z = ^s_i.z;

    always_comb begin
        case (s_i.quad)
            2'd0:    begin us =  s_i.y; uc =  s_i.x; end
            2'd1:    begin us =  s_i.x; uc = -s_i.y; end
            2'd2:    begin us = -s_i.y; uc = -s_i.x; end
            default: begin us = -s_i.x; uc =  s_i.y; end
        endcase
        ws = {{(PW-DW){us[DW-1]}}, us};
        wc = {{(PW-DW){uc[DW-1]}}, uc};
        wr = {{(PW-RAD_W){s_i.rad[RAD_W-1]}}, s_i.rad};
        r_d = r_q;
        if (en) begin
            r_d.vld = s_i.vld;
            r_d.s   = clip(round_shift(ws * wr, s_i.gain));
            r_d.c   = clip(round_shift(wc * wr, s_i.gain));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign r_o = r_q;
endmodule

// File: rtl/pvr_polar_rect.sv
`timescale 1ns/1ps
module pvr_polar_rect
    import pvr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [ANG_W-1:0]         angle_in,
    input  logic signed [RAD_W-1:0]  radius_in,
    input  logic [1:0]               gain_sel,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [OUT_W-1:0]  sin_out,
    output logic signed [OUT_W-1:0]  cos_out
);
    localparam logic signed [DW-1:0] X0 = start_len();

    logic en;
    rot_t head_d, head_q;
    rot_t chain [0:ITER];
    res_t res;

    assign en       = !res.vld || out_ready;
    assign in_ready = en;

    always_comb begin
        head_d = head_q;
        if (en) begin
            head_d.vld  = in_valid;
            head_d.x    = X0;
            head_d.y    = '0;
            head_d.z    = DW'({angle_in[IDX_W-1:0], {ZX{1'b0}}});
            head_d.quad = angle_in[ANG_W-1 -: 2];
            head_d.rad  = radius_in;
            head_d.gain = gain_decode(gain_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) head_q <= '0;
        else        head_q <= head_d;
    end

    assign chain[0] = head_q;

    for (genvar g = 0; g < ITER; g++) begin : g_rot
        pvr_rot_stage #(.STEP(g)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .s_i   (chain[g]),
            .s_o   (chain[g+1])
        );
    end

    pvr_scale u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .s_i   (chain[ITER]),
        .r_o   (res)
    );

    assign out_valid = res.vld;
    assign sin_out   = res.s;
    assign cos_out   = res.c;
endmodule

// File: rtl/pvr_polar_rect_chk.sv
`timescale 1ns/1ps
module pvr_polar_rect_chk #(
    parameter int DEPTH = pvr_pkg::ITER + 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [17:0] sin_out,
    input logic [17:0] cos_out
);
    logic [7:0] infl_d, infl_q;

    always_comb begin
        infl_d = infl_q;
        if (in_valid && in_ready)   infl_d = infl_d + 8'd1;
        if (out_valid && out_ready) infl_d = infl_d - 8'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) infl_q <= '0;
        else        infl_q <= infl_d;
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(sin_out) && $stable(cos_out)); // R8
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R8
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R9
    AST_NO_ORPHAN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> infl_q != 8'd0); // R7
    AST_BOUNDED_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        infl_q <= 8'(DEPTH)); // R7
endmodule

bind pvr_polar_rect pvr_polar_rect_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .sin_out   (sin_out),
    .cos_out   (cos_out)
);

// File: tb/tb_pvr_polar_rect.sv
`timescale 1ns/1ps
module tb_pvr_polar_rect;
    localparam int  LAT  = 23;
    localparam int  TOL  = 2;
    localparam int  NTX  = 4096;
    localparam real PI2  = 6.283185307179586;
    localparam int  OMAX = 131071;
    localparam int  OMIN = -131072;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [15:0] angle_in = '0;
    logic signed [15:0] radius_in = '0;
    logic [1:0] gain_sel = 2'b01;
    logic out_valid;
    logic out_ready = 1'b1;
    logic signed [17:0] sin_out, cos_out;

    always #10 clk = ~clk;

    pvr_polar_rect dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .angle_in(angle_in), .radius_in(radius_in), .gain_sel(gain_sel),
        .out_valid(out_valid), .out_ready(out_ready),
        .sin_out(sin_out), .cos_out(cos_out)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int exp_s [NTX];
    int exp_c [NTX];
    int acc_c [NTX];
    real amp [NTX];
    bit lat_on [NTX];
    string tag [NTX];
    int wr = 0, rd = 0;
    bit lat_mode = 1'b1;
    bit bp_on = 1'b0;
    bit stall_p = 1'b0;
    int ps = 0, pc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #2;
        out_ready = bp_on ? 1'($urandom_range(1)) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    function automatic int rnd_clip(input real v);
        int r;
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        if (r > OMAX) r = OMAX;
        if (r < OMIN) r = OMIN;
        return r;
    endfunction

    function automatic real absr(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic send(input int ang, input int rad, input logic [1:0] g, input string t);
        real k, th, es, ec;
        k  = (g == 2'b10) ? 0.5 : ((g == 2'b11) ? 2.0 : 1.0);
        th = real'(ang) * PI2 / 65536.0;
        es = 4.0 * k * real'(rad) * $sin(th);
        ec = 4.0 * k * real'(rad) * $cos(th);
        exp_s[wr]  = rnd_clip(es);
        exp_c[wr]  = rnd_clip(ec);
        amp[wr]    = (absr(es) < 131070.0 && absr(ec) < 131070.0) ? 4.0 * k * absr(real'(rad)) : -1.0;
        tag[wr]    = t;
        lat_on[wr] = lat_mode;
        @(negedge clk); #1;
        in_valid  = 1'b1;
        angle_in  = ang[15:0];
        radius_in = rad[15:0];
        gain_sel  = g;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        acc_c[wr] = cyc;
        wr++;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (rd != wr) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_p)
                check(out_valid && sin_out == 18'(ps) && cos_out == 18'(pc), "R8",
                      "held output", longint'(sin_out), longint'(ps));
            stall_p = out_valid && !out_ready;
            if (stall_p) begin
                ps = int'(sin_out);
                pc = int'(cos_out);
                check(!in_ready, "R8", "in_ready during stall", longint'(in_ready), 0);
            end
            if (out_valid && out_ready) begin
                if (rd >= wr) begin
                    check(1'b0, "R7", "result without sample", rd, wr);
                end else begin
                    int ds, dc;
                    ds = int'(sin_out) - exp_s[rd];
                    dc = int'(cos_out) - exp_c[rd];
                    check(ds <= TOL && ds >= -TOL, tag[rd], "sin_out", longint'(sin_out), exp_s[rd]);
                    check(dc <= TOL && dc >= -TOL, tag[rd], "cos_out", longint'(cos_out), exp_c[rd]);
                    if (amp[rd] >= 0.0) begin
                        real a;
                        a = $sqrt(real'(sin_out) * real'(sin_out) + real'(cos_out) * real'(cos_out));
                        check(absr(a - amp[rd]) <= 0.001 * amp[rd] + 3.0, "R10", "magnitude",
                              longint'($rtoi(a)), longint'($rtoi(amp[rd])));
                    end
                    if (lat_on[rd])
                        check(cyc - acc_c[rd] == LAT, "R7", "latency", cyc - acc_c[rd], LAT);
                    rd++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R7 watchdog: actual %0d results expected %0d", rd, wr);
        report();
        $finish;
    end

    initial begin
        int axis [11] = '{0, 16383, 16384, 16385, 32767, 32768, 32769, 49151, 49152, 49153, 65535};
        void'($urandom(32'd11));
        repeat (3) @(negedge clk);
        check(!out_valid, "R9", "out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R9", "out_valid after reset", longint'(out_valid), 0);
        check(in_ready, "R9", "in_ready after reset", longint'(in_ready), 1);

        // R6 axis codes and neighbours
        foreach (axis[i]) send(axis[i], 30000, 2'b01, "R6");
        // R3 each defined gain code, R4 reserved code, at 45 degrees
        send(8192, 20000, 2'b10, "R3");
        send(8192, 20000, 2'b01, "R3");
        send(8192, 20000, 2'b11, "R3");
        send(8192, 20000, 2'b00, "R4");
        send(40000, -17000, 2'b00, "R4");
        // R5 clipping at both rails
        send(16384, 32767, 2'b11, "R5");
        send(49152, 32767, 2'b11, "R5");
        send(49152, -32768, 2'b01, "R5");
        send(16384, -32768, 2'b01, "R5");
        send(8192, 32000, 2'b11, "R5");
        drain();

        // R1 dense sweep of the binary angle
        for (int a = 0; a < 65536; a += 64) send(a, 12000, 2'b11, "R1");
        drain();

        // R2 random angle, radius and gain
        for (int n = 0; n < 1000; n++)
            send(int'($urandom_range(65535)), int'($urandom_range(65535)) - 32768,
                 2'($urandom_range(3)), "R2");
        drain();

        // R8 random backpressure
        lat_mode = 1'b0;
        bp_on    = 1'b1;
        for (int n = 0; n < 200; n++)
            send(int'($urandom_range(65535)), int'($urandom_range(65535)) - 32768,
                 2'($urandom_range(3)), "R8");
        drain();
        bp_on = 1'b0;
        drain();

        check(rd == wr, "R7", "results matched samples", rd, wr);
        report();
        $finish;
    end
endmodule